// File: doc/BRIEF.md
# Shared-Table Three-Channel Volume Mixer

This block turns three 4-bit amplitude codes into 8-bit unsigned output levels on a logarithmic scale, and also produces a 10-bit unsigned mix that is the sum of the three levels. One registered lookup table serves all three channels. A small sequencer steps the table address through channel A, then B, then C. It advances only on clock-enable strobes. The pipeline has no wait states of its own. It depends on the clock enable having at least one idle clock between strobes: that idle clock lets the table register settle on the next channel's entry before the next strobe takes it.

A set of codes enters through a valid/ready handshake. The producer holds `in_valid` and the codes until a strobe edge finds `in_ready` high. `in_ready` then stays low for the whole sweep, and codes offered during that time wait. The static parameter `COMP` (0 to 3) picks one of four compressed curves. They model how far the output load squeezes the dynamic range: about 43.6 dB, 29.1 dB, 21.8 dB and 13.4 dB.

Top module: `vmix_mixer`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `lvl_a`, `lvl_b`, `lvl_c` and `mix` read 0 and `in_ready` reads 1.
- R2: A code set is accepted at a rising edge where `clk_en`, `in_valid` and `in_ready` are all high. `in_ready` falls at that edge and rises again at the edge of the third following enabled cycle.
- R3: While `in_ready` is low, `in_valid` and the code inputs have no effect. The sweep that is running produces levels for the codes it accepted, and no extra sweep starts once `in_valid` is dropped.
- R4: After acceptance, `lvl_a` is written at the first enabled edge, `lvl_b` at the second and `lvl_c` at the third. The other channels hold their previous values meanwhile. This assumes `clk_en` is never high on two consecutive clocks.
- R5: For every `COMP` value, code 0 gives level 0 and code 15 gives level 255.
- R6: Levels for codes 1 to 14 depend on `COMP`: 0 → 2,3,5,6,9,13,18,24,34,48,67,93,131,182; 1 → 11,14,17,22,27,34,43,53,67,83,104,130,163,204; 2 → 24,29,34,40,48,57,67,79,93,110,131,154,182,216; 3 → 60,67,74,82,91,101,112,124,138,152,169,187,208,230.
- R7: `mix` takes the value `lvl_a + lvl_b + lvl_c` of the finished sweep at the edge where `lvl_c` is written. It reaches 765 without wrapping, and no other edge changes it.
- R8: All outputs hold their values between sweeps and on every clock where `clk_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low |
| clk | input | 1 | System clock |
| clk_en | input | 1 | Strobe that advances the block; at least one idle clock between strobes |
| in_valid | input | 1 | A code set is offered |
| in_ready | output | 1 | High when a new code set can be taken |
| code_a | input | 4 | Amplitude code, channel A |
| code_b | input | 4 | Amplitude code, channel B |
| code_c | input | 4 | Amplitude code, channel C |
| lvl_a | output | 8 | Unsigned level, channel A |
| lvl_b | output | 8 | Unsigned level, channel B |
| lvl_c | output | 8 | Unsigned level, channel C |
| mix | output | 10 | Unsigned sum of the three levels |

## Verification
The bench builds the block with `COMP` = 0. That is the widest curve, where the low codes map to small, closely spaced levels, so a swapped or shifted table entry shows up at the outputs. The bench keeps its own tables for all four curves behind one local parameter, so rebuilding it at 1, 2 or 3 checks those curves without further edits. The strobe gaps vary between one and three idle clocks, which covers the tightest spacing the shared table can tolerate.

// File: rtl/vmix_pkg.sv
package vmix_pkg;
  localparam int CODE_W = 4;
  localparam int LVL_W  = 8;
  localparam int NCURVE = 4;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [LVL_W-1:0]  level_t;

  // Level for an amplitude code on one of the compression curves.
  function automatic level_t curve_level(input int comp, input code_t code);
    level_t t [16];
    case (comp)
      1:       t = '{8'd0, 8'd11, 8'd14, 8'd17, 8'd22, 8'd27, 8'd34, 8'd43,
                     8'd53, 8'd67, 8'd83, 8'd104, 8'd130, 8'd163, 8'd204, 8'd255};
      2:       t = '{8'd0, 8'd24, 8'd29, 8'd34, 8'd40, 8'd48, 8'd57, 8'd67,
                     8'd79, 8'd93, 8'd110, 8'd131, 8'd154, 8'd182, 8'd216, 8'd255};
      3:       t = '{8'd0, 8'd60, 8'd67, 8'd74, 8'd82, 8'd91, 8'd101, 8'd112,
                     8'd124, 8'd138, 8'd152, 8'd169, 8'd187, 8'd208, 8'd230, 8'd255};
      default: t = '{8'd0, 8'd2, 8'd3, 8'd5, 8'd6, 8'd9, 8'd13, 8'd18,
                     8'd24, 8'd34, 8'd48, 8'd67, 8'd93, 8'd131, 8'd182, 8'd255};
    endcase
    return t[code];
  endfunction
endpackage

// File: rtl/vmix_seq.sv
// Sweep sequencer: latches a code set and steps the shared table address.
module vmix_seq #(
  parameter int NCH    = 3,
  parameter int CODE_W = 4,
  localparam int STG_W = $clog2(NCH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clk_en,
  input  logic                         in_valid,
  input  logic [NCH-1:0][CODE_W-1:0]   codes_in,
  output logic                         in_ready,
  output logic [STG_W-1:0]             stage,
  output logic [CODE_W-1:0]            sel_code
);
  logic [NCH-1:0][CODE_W-1:0] codes_q;

  assign in_ready = (stage == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage   <= '0;
      codes_q <= '0;
    end else if (clk_en) begin
      if (stage == '0) begin
        if (in_valid) begin
          codes_q <= codes_in;
          stage   <= STG_W'(1);
        end
      end else if (stage == STG_W'(NCH)) begin
        stage <= '0;
      end else begin
        stage <= stage + STG_W'(1);
      end
    end
  end

  // Stage k (1..NCH) points the table at channel k-1.
  always_comb begin
    sel_code = '0;
    for (int k = 0; k < NCH; k++) begin
      if (stage == STG_W'(k + 1)) sel_code = codes_q[k];
    end
  end
endmodule

// File: rtl/vmix_lut.sv
// Shared volume table with a registered read; reloads on every clock.
module vmix_lut
  import vmix_pkg::*;
#(
  parameter int COMP = 0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  code_t  code,
  output level_t level_q
);
  generate
    if (COMP >= 0 && COMP < NCURVE) begin : g_curve
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= curve_level(COMP, code);
      end
    end else begin : g_fallback
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= curve_level(0, code);
      end
    end
  endgenerate
endmodule

// File: rtl/vmix_out.sv
// Channel output registers and the sweep-aligned sum.
module vmix_out #(
  parameter int NCH   = 3,
  parameter int LVL_W = 8,
  parameter int STG_W = 2,
  localparam int SUM_W = LVL_W + $clog2(NCH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clk_en,
  input  logic [STG_W-1:0]           stage,
  input  logic [LVL_W-1:0]           lut_q,
  output logic [NCH-1:0][LVL_W-1:0]  levels,
  output logic [SUM_W-1:0]           mix
);
  logic [LVL_W-1:0] lvl_r [NCH];
  logic [SUM_W-1:0] acc;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    lvl_r[k] <= '0;
      else if (clk_en && stage == STG_W'(k + 1))     lvl_r[k] <= lut_q;
    end
    assign levels[k] = lvl_r[k];
  end

  // Last channel comes straight from the table so the sum uses one sweep.
  always_comb begin
    acc = SUM_W'(lut_q);
    for (int k = 0; k < NCH - 1; k++) acc = acc + SUM_W'(lvl_r[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  mix <= '0;
    else if (clk_en && stage == STG_W'(NCH))     mix <= acc;
  end
endmodule

// File: rtl/vmix_mixer.sv
module vmix_mixer
  import vmix_pkg::*;
#(
  parameter int COMP = 0
) (
  input  logic        rst_n,
  input  logic        clk,
  input  logic        clk_en,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [3:0]  code_a,
  input  logic [3:0]  code_b,
  input  logic [3:0]  code_c,
  output logic [7:0]  lvl_a,
  output logic [7:0]  lvl_b,
  output logic [7:0]  lvl_c,
  output logic [9:0]  mix
);
  localparam int NCH   = 3;
  localparam int STG_W = $clog2(NCH + 1);
  localparam int SUM_W = LVL_W + $clog2(NCH);

  logic [NCH-1:0][CODE_W-1:0] codes;
  logic [NCH-1:0][LVL_W-1:0]  levels;
  logic [STG_W-1:0]           stage;
  code_t                      sel_code;
  level_t                     lut_q;
  logic [SUM_W-1:0]           mix_w;

  assign codes = {code_c, code_b, code_a};

  vmix_seq #(.NCH(NCH), .CODE_W(CODE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .in_valid(in_valid),
    .codes_in(codes), .in_ready(in_ready), .stage(stage), .sel_code(sel_code)
  );

  vmix_lut #(.COMP(COMP)) u_lut (
    .clk(clk), .rst_n(rst_n), .code(sel_code), .level_q(lut_q)
  );

  vmix_out #(.NCH(NCH), .LVL_W(LVL_W), .STG_W(STG_W)) u_out (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .stage(stage),
    .lut_q(lut_q), .levels(levels), .mix(mix_w)
  );

  assign lvl_a = levels[0];
  assign lvl_b = levels[1];
  assign lvl_c = levels[2];
  assign mix   = mix_w;
endmodule

// File: rtl/vmix_checker.sv
module vmix_checker (
  input logic       rst_n,
  input logic       clk,
  input logic       clk_en,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] lvl_a,
  input logic [7:0] lvl_b,
  input logic [7:0] lvl_c,
  input logic [9:0] mix
);
  // R1: reset clears outputs and opens the input
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (lvl_a == 8'd0 && lvl_b == 8'd0 && lvl_c == 8'd0
                                && mix == 10'd0 && in_ready);
    end
  end

  // R2: acceptance closes the input
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && in_valid && in_ready |=> !in_ready);

  // R2: input reopens only on an enabled edge
  a_r2_ready_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(clk_en));

  // R4: strobes must leave an idle clock for the shared table
  a_r4_enable_gap: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |=> !clk_en);

  // R8: nothing moves without a strobe
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(lvl_a) && $stable(lvl_b) && $stable(lvl_c) && $stable(mix));

  // R7: mix changes only as a sweep ends
  a_r7_mix_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mix) |-> $rose(in_ready));

  // R7: mix equals the channel sum when a sweep ends
  a_r7_mix_sum: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> mix == 10'(lvl_a) + 10'(lvl_b) + 10'(lvl_c));
endmodule

bind vmix_mixer vmix_checker u_chk (
  .rst_n(rst_n), .clk(clk), .clk_en(clk_en), .in_valid(in_valid),
  .in_ready(in_ready), .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_c(lvl_c), .mix(mix)
);

// File: tb/vmix_mixer_test.sv
`timescale 1ns/1ps
module vmix_mixer_test;
  localparam int TB_COMP = 0;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] c;
    logic [9:0] m;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] code_a = '0, code_b = '0, code_c = '0;
  logic       in_ready;
  logic [7:0] lvl_a, lvl_b, lvl_c;
  logic [9:0] mix;

  int   n_cmp = 0;
  int   n_bad = 0;
  exp_t q[$];
  exp_t last_exp = '0;
  logic rdy_prev = 1'b1;
  logic [7:0] lf = 8'h5a;
  int   gap = 0;

  vmix_mixer #(.COMP(TB_COMP)) uut (
    .rst_n(rst_n), .clk(clk), .clk_en(clk_en), .in_valid(in_valid),
    .in_ready(in_ready), .code_a(code_a), .code_b(code_b), .code_c(code_c),
    .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_c(lvl_c), .mix(mix)
  );

  always #2 clk = ~clk;  // 250 MHz

  // Expected curves, taken from the requirement tables (R5, R6).
  function automatic logic [7:0] ref_level(input int comp, input logic [3:0] c);
    logic [7:0] t [16];
    case (comp)
      1: t = '{0, 11, 14, 17, 22, 27, 34, 43, 53, 67, 83, 104, 130, 163, 204, 255};
      2: t = '{0, 24, 29, 34, 40, 48, 57, 67, 79, 93, 110, 131, 154, 182, 216, 255};
      3: t = '{0, 60, 67, 74, 82, 91, 101, 112, 124, 138, 152, 169, 187, 208, 230, 255};
      default: t = '{0, 2, 3, 5, 6, 9, 13, 18, 24, 34, 48, 67, 93, 131, 182, 255};
    endcase
    return t[c];
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Strobe generator: one-clock pulses separated by 1 to 3 idle clocks.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst_n) begin
        clk_en = 1'b0;
      end else if (gap == 0) begin
        clk_en = 1'b1;
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        gap = 1 + int'(lf % 3);
      end else begin
        clk_en = 1'b0;
        gap--;
      end
    end
  end

  // Monitor: a rising in_ready marks a finished sweep.
  always @(negedge clk) begin
    if (rst_n) begin
      if (in_ready && !rdy_prev) begin
        if (q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R3: unexpected sweep, got %0d expected none", mix);
        end else begin
          exp_t e;
          e = q.pop_front();
          check("R6 lvl_a", lvl_a, e.a);
          check("R6 lvl_b", lvl_b, e.b);
          check("R6 lvl_c", lvl_c, e.c);
          check("R7 mix", mix, e.m);
          last_exp = e;
        end
      end
      rdy_prev <= in_ready;
    end else begin
      rdy_prev <= 1'b1;
    end
  end

  // Driver: offers a code set, waits for acceptance, queues the expectation.
  task automatic send(input logic [3:0] a, input logic [3:0] b, input logic [3:0] c,
                      input bit junk);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    code_a = a; code_b = b; code_c = c;
    while (!(clk_en && in_ready)) @(negedge clk);
    e.a = ref_level(TB_COMP, a);
    e.b = ref_level(TB_COMP, b);
    e.c = ref_level(TB_COMP, c);
    e.m = 10'(e.a) + 10'(e.b) + 10'(e.c);
    q.push_back(e);
    @(negedge clk);  // acceptance edge has passed
    if (junk) begin
      code_a = ~a; code_b = ~b; code_c = ~c;
      @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic step_en();
    while (!clk_en) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    exp_t p;
    logic [7:0] ya;
    logic [7:0] yb;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 lvl_a", lvl_a, 0);
    check("R1 lvl_b", lvl_b, 0);
    check("R1 lvl_c", lvl_c, 0);
    check("R1 mix", mix, 0);
    check("R1 in_ready", in_ready, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5: end points
    send(4'd15, 4'd15, 4'd15, 1'b0); drain();
    check("R7 full scale mix", mix, 765);
    send(4'd0, 4'd0, 4'd0, 1'b0); drain();
    check("R5 zero mix", mix, 0);
    send(4'd0, 4'd15, 4'd0, 1'b0);
    send(4'd15, 4'd0, 4'd15, 1'b0);

    // R6: every code on each channel position
    for (int k = 0; k < 16; k++) begin
      send(4'(k), 4'(15 - k), 4'((k * 7) % 16), 1'b0);
    end
    drain();

    // R4: write order, one channel per enabled edge
    p = last_exp;
    ya = ref_level(TB_COMP, 4'd3);
    yb = ref_level(TB_COMP, 4'd9);
    send(4'd3, 4'd9, 4'd12, 1'b0);
    step_en();
    check("R4 A first", lvl_a, ya);
    check("R4 B held", lvl_b, p.b);
    check("R4 C held", lvl_c, p.c);
    check("R2 busy", in_ready, 0);
    step_en();
    check("R4 B second", lvl_b, yb);
    check("R4 C still held", lvl_c, p.c);
    check("R7 mix held", mix, p.m);
    drain();

    // R3: inputs changing during a sweep are ignored
    send(4'd1, 4'd2, 4'd14, 1'b1);
    drain();
    repeat (12) @(negedge clk);
    check("R3 no extra sweep", in_ready, 1);
    check("R3 lvl_a kept", lvl_a, ref_level(TB_COMP, 4'd1));
    check("R3 mix kept", mix, last_exp.m);

    // R2: back-to-back offers
    send(4'd5, 4'd6, 4'd7, 1'b0);
    send(4'd8, 4'd10, 4'd11, 1'b0);
    drain();

    // R8: outputs hold while idle
    repeat (20) @(negedge clk);
    check("R8 lvl_a hold", lvl_a, last_exp.a);
    check("R8 lvl_b hold", lvl_b, last_exp.b);
    check("R8 lvl_c hold", lvl_c, last_exp.c);
    check("R8 mix hold", mix, last_exp.m);

    // R1: reset in the middle of a sweep
    send(4'd13, 4'd13, 4'd13, 1'b0);
    step_en();
    rst_n = 1'b0;
    q.delete();
    @(negedge clk);
    check("R1 mid lvl_a", lvl_a, 0);
    check("R1 mid mix", mix, 0);
    check("R1 mid ready", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send(4'd2, 4'd4, 4'd6, 1'b0);
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule